// File: doc/BRIEF.md
# Four-Wide Register Renamer

This block sits in the front end of an out-of-order core and translates a group of four instructions per clock from architectural register names to physical register names. Each lane of the group names one destination and two source architectural registers. The block keeps a speculative map table from architectural to physical registers and a circular free list of unused physical registers. Every destination gets a fresh physical register from the free list. Every source is looked up in the map. A source that names the destination of an older lane in the same group takes that lane's new physical register instead.

Every accepted group receives a small sequence tag. When the group is accepted, the block saves a snapshot of the map table and of the free-list read pointer in the checkpoint slot that the tag selects. On a misspeculation the pipeline presents a tag, and the block returns the map and the free-list pointer to the state they had just before that group. A separate release port hands one physical register per cycle back to the free list. Retirement logic drives this port.

Top module: `rn_rename4`

## Requirements
- R1: After reset, architectural register r maps to physical register r. The free list holds physical registers ARCH to PHYS-1 in ascending order, the next tag is 0, and out_valid is low.
- R2: A group is accepted in a cycle where in_valid is high and stall is low. Its result appears on the registered outputs one cycle later, with out_valid high for exactly that cycle.
- R3: Lane i of an accepted group receives the i-th entry counted from the free-list read pointer (lane 0 first). The pointer then advances by four.
- R4: A source that matches no older lane's destination in its group takes the map table value current at acceptance.
- R5: A source that matches the destination of one or more older lanes in its group takes the new physical register of the youngest such older lane.
- R6: If several lanes of one group write the same architectural register, later groups see the youngest lane's physical register for it.
- R7: stall is high when fewer than four registers are free or when restore_valid is high. A stalled group is not consumed: out_valid stays low and the free list and map are unchanged.
- R8: While rel_valid is high, rel_preg is appended at the tail of the free list. Later allocations hand it out in FIFO order, and it counts toward the free total from the next cycle.
- R9: out_tag carries the group's sequence number. The number starts at 0 and increases by one per accepted group, modulo the slot count (4 by default).
- R10: A cycle with restore_valid high loads the map table and the free-list read pointer saved for restore_tag, and the next accepted group takes restore_tag as its tag. A release in that same cycle is still appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A rename group is offered |
| in_dst | input | 4*AW | Destination architectural registers, lane i at bits [i*AW +: AW] |
| in_src_a | input | 4*AW | First source architectural registers per lane |
| in_src_b | input | 4*AW | Second source architectural registers per lane |
| stall | output | 1 | The offered group is not taken this cycle |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_preg | input | PW | Physical register being returned |
| restore_valid | input | 1 | Roll the map back to a checkpoint |
| restore_tag | input | TW | Tag of the group to roll back to |
| out_valid | output | 1 | Registered result is valid |
| out_tag | output | TW | Sequence tag of the result group |
| out_pdst | output | 4*PW | New physical destinations per lane |
| out_psrc_a | output | 4*PW | Physical first sources per lane |
| out_psrc_b | output | 4*PW | Physical second sources per lane |

## Verification
A rollback and a register release can arrive in the same cycle. The rollback rewinds the free-list read pointer, and the release moves the write pointer, so the two must combine without losing the returned register. The sweep issues rollbacks periodically, and on even-numbered steps each rollback coincides with a release. The bench model then predicts which entries the following groups receive, including the entry that was just returned. Allocation and release also overlap on many ordinary cycles, and the stall decision is judged against the model's free count before each edge.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_ARCH_REGS  = 32;
  localparam int RN_PHYS_REGS  = 64;
  localparam int RN_LANES      = 4;
  localparam int RN_CKPT_SLOTS = 4;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
  import rn_pkg::*;
#(
  parameter int ARCH  = RN_ARCH_REGS,
  parameter int PHYS  = RN_PHYS_REGS,
  parameter int LANES = RN_LANES,
  localparam int PW   = $clog2(PHYS),
  localparam int IW   = $clog2(PHYS),
  localparam int PTRW = IW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_en,
  input  logic                  rel_en,
  input  logic [PW-1:0]         rel_preg,
  input  logic                  rewind_en,
  input  logic [PTRW-1:0]       rewind_head,
  output logic [PTRW-1:0]       head,
  output logic                  enough,
  output logic [LANES*PW-1:0]   alloc_pregs
);

  logic [PW-1:0]   slot_q [PHYS];
  logic [PTRW-1:0] head_q, head_d;
  logic [PTRW-1:0] tail_q, tail_d;
  logic [PTRW-1:0] fill;

  assign fill   = tail_q - head_q;
  assign enough = (fill >= PTRW'(LANES));
  assign head   = head_q;

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    logic [IW-1:0] rd_idx;
    assign rd_idx = head_q[IW-1:0] + IW'(l);
    assign alloc_pregs[l*PW +: PW] = slot_q[rd_idx];
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (rewind_en)     head_d = rewind_head;
    else if (alloc_en) head_d = head_q + PTRW'(LANES);
    if (rel_en)        tail_d = tail_q + PTRW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= PTRW'(PHYS - ARCH);
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS; i++)
        slot_q[i] <= (i < PHYS - ARCH) ? PW'(ARCH + i) : '0;
    end else if (rel_en) begin
      slot_q[tail_q[IW-1:0]] <= rel_preg;
    end
  end

  AST_FL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !rewind_en) |-> enough) else $error("free list underflow"); // R7

  AST_FL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> (fill < PTRW'(PHYS))) else $error("free list overflow"); // R8

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
  import rn_pkg::*;
#(
  parameter int ARCH  = RN_ARCH_REGS,
  parameter int PHYS  = RN_PHYS_REGS,
  parameter int LANES = RN_LANES,
  parameter int SLOTS = RN_CKPT_SLOTS,
  localparam int AW   = $clog2(ARCH),
  localparam int PW   = $clog2(PHYS),
  localparam int SW   = $clog2(SLOTS),
  localparam int PTRW = $clog2(PHYS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES*AW-1:0]  rd_a_arch,
  input  logic [LANES*AW-1:0]  rd_b_arch,
  output logic [LANES*PW-1:0]  rd_a_phys,
  output logic [LANES*PW-1:0]  rd_b_phys,
  input  logic                 wr_en,
  input  logic [LANES*AW-1:0]  wr_arch,
  input  logic [LANES*PW-1:0]  wr_phys,
  input  logic [SW-1:0]        ckpt_slot,
  input  logic [PTRW-1:0]      ckpt_head,
  input  logic                 rewind_en,
  input  logic [SW-1:0]        rewind_slot,
  output logic [PTRW-1:0]      rewind_head
);

  logic [PW-1:0]   map_q [ARCH];
  logic [PW-1:0]   map_d [ARCH];
  logic [PW-1:0]   snap_map  [SLOTS][ARCH];
  logic [PTRW-1:0] snap_head [SLOTS];

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_a_phys[l*PW +: PW] = map_q[rd_a_arch[l*AW +: AW]];
    assign rd_b_phys[l*PW +: PW] = map_q[rd_b_arch[l*AW +: AW]];
  end

  assign rewind_head = snap_head[rewind_slot];

  // lanes applied oldest first, so the youngest writer of a register lands last
  always_comb begin
    map_d = map_q;
    if (rewind_en) begin
      map_d = snap_map[rewind_slot];
    end else if (wr_en) begin
      for (int l = 0; l < LANES; l++)
        map_d[wr_arch[l*AW +: AW]] = wr_phys[l*PW +: PW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH; i++) map_q[i] <= PW'(i);
    end else if (rewind_en || wr_en) begin
      map_q <= map_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rewind_en) begin
      snap_map[ckpt_slot]  <= map_q;
      snap_head[ckpt_slot] <= ckpt_head;
    end
  end

  AST_MAP_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rewind_en && (wr_arch[AW-1:0] == wr_arch[(LANES-1)*AW +: AW]))
    |=> (map_q[$past(wr_arch[AW-1:0])] == $past(wr_phys[(LANES-1)*PW +: PW])))
    else $error("youngest writer lost"); // R6

endmodule

// File: rtl/rn_bypass.sv
module rn_bypass
  import rn_pkg::*;
#(
  parameter int LANES = RN_LANES,
  parameter int AW    = $clog2(RN_ARCH_REGS),
  parameter int PW    = $clog2(RN_PHYS_REGS)
) (
  input  logic [LANES*AW-1:0] dst_arch,
  input  logic [LANES*AW-1:0] src_a_arch,
  input  logic [LANES*AW-1:0] src_b_arch,
  input  logic [LANES*PW-1:0] map_a_phys,
  input  logic [LANES*PW-1:0] map_b_phys,
  input  logic [LANES*PW-1:0] new_phys,
  output logic [LANES*PW-1:0] src_a_phys,
  output logic [LANES*PW-1:0] src_b_phys
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PW-1:0] pa, pb;
    // scan older lanes oldest to youngest; the last hit wins
    always_comb begin
      pa = map_a_phys[l*PW +: PW];
      pb = map_b_phys[l*PW +: PW];
      for (int o = 0; o < l; o++) begin
        if (src_a_arch[l*AW +: AW] == dst_arch[o*AW +: AW]) pa = new_phys[o*PW +: PW];
        if (src_b_arch[l*AW +: AW] == dst_arch[o*AW +: AW]) pb = new_phys[o*PW +: PW];
      end
    end
    assign src_a_phys[l*PW +: PW] = pa;
    assign src_b_phys[l*PW +: PW] = pb;
  end

endmodule

// File: rtl/rn_rename4.sv
module rn_rename4
  import rn_pkg::*;
#(
  parameter int ARCH  = RN_ARCH_REGS,
  parameter int PHYS  = RN_PHYS_REGS,
  parameter int LANES = RN_LANES,
  parameter int SLOTS = RN_CKPT_SLOTS,
  localparam int AW   = $clog2(ARCH),
  localparam int PW   = $clog2(PHYS),
  localparam int TW   = $clog2(SLOTS),
  localparam int PTRW = $clog2(PHYS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*AW-1:0] in_dst,
  input  logic [LANES*AW-1:0] in_src_a,
  input  logic [LANES*AW-1:0] in_src_b,
  output logic                stall,
  input  logic                rel_valid,
  input  logic [PW-1:0]       rel_preg,
  input  logic                restore_valid,
  input  logic [TW-1:0]       restore_tag,
  output logic                out_valid,
  output logic [TW-1:0]       out_tag,
  output logic [LANES*PW-1:0] out_pdst,
  output logic [LANES*PW-1:0] out_psrc_a,
  output logic [LANES*PW-1:0] out_psrc_b
);

  logic                accept;
  logic                enough;
  logic [PTRW-1:0]     fl_head, snap_head;
  logic [LANES*PW-1:0] new_phys, map_a, map_b, psa, psb;
  logic [TW-1:0]       seq_q, seq_d;
  logic                vld_q;
  logic [TW-1:0]       tag_q;
  logic [LANES*PW-1:0] pdst_q, psa_q, psb_q;

  assign stall  = !enough || restore_valid;
  assign accept = in_valid && !stall;

  rn_freelist #(.ARCH(ARCH), .PHYS(PHYS), .LANES(LANES)) u_freelist (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (accept),
    .rel_en      (rel_valid),
    .rel_preg    (rel_preg),
    .rewind_en   (restore_valid),
    .rewind_head (snap_head),
    .head        (fl_head),
    .enough      (enough),
    .alloc_pregs (new_phys)
  );

  rn_map_table #(.ARCH(ARCH), .PHYS(PHYS), .LANES(LANES), .SLOTS(SLOTS)) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_arch   (in_src_a),
    .rd_b_arch   (in_src_b),
    .rd_a_phys   (map_a),
    .rd_b_phys   (map_b),
    .wr_en       (accept),
    .wr_arch     (in_dst),
    .wr_phys     (new_phys),
    .ckpt_slot   (seq_q),
    .ckpt_head   (fl_head),
    .rewind_en   (restore_valid),
    .rewind_slot (restore_tag),
    .rewind_head (snap_head)
  );

  rn_bypass #(.LANES(LANES), .AW(AW), .PW(PW)) u_bypass (
    .dst_arch   (in_dst),
    .src_a_arch (in_src_a),
    .src_b_arch (in_src_b),
    .map_a_phys (map_a),
    .map_b_phys (map_b),
    .new_phys   (new_phys),
    .src_a_phys (psa),
    .src_b_phys (psb)
  );

  always_comb begin
    seq_d = seq_q;
    if (restore_valid) seq_d = restore_tag;
    else if (accept)   seq_d = seq_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      vld_q <= 1'b0;
    end else begin
      seq_q <= seq_d;
      vld_q <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q  <= seq_q;
      pdst_q <= new_phys;
      psa_q  <= psa;
      psb_q  <= psb;
    end
  end

  assign out_valid  = vld_q;
  assign out_tag    = tag_q;
  assign out_pdst   = pdst_q;
  assign out_psrc_a = psa_q;
  assign out_psrc_b = psb_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stall) |=> !out_valid) else $error("stalled group consumed"); // R7

  AST_RESTORE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> !out_valid) else $error("group taken during restore"); // R10

  AST_LANE1_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_src_a[AW +: AW] == in_dst[0 +: AW]))
    |=> (out_psrc_a[PW +: PW] == out_pdst[0 +: PW])) else $error("lane 1 bypass missed"); // R5

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall) |=> out_valid) else $error("accepted group lost"); // R2

endmodule

// File: tb/rn_rename4_tb.sv
module rn_rename4_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int PW = 6;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [4*AW-1:0] in_dst, in_src_a, in_src_b;
  logic stall;
  logic rel_valid;
  logic [PW-1:0] rel_preg;
  logic restore_valid;
  logic [TW-1:0] restore_tag;
  logic out_valid;
  logic [TW-1:0] out_tag;
  logic [4*PW-1:0] out_pdst, out_psrc_a, out_psrc_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  rn_rename4 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .stall(stall),
    .rel_valid(rel_valid), .rel_preg(rel_preg),
    .restore_valid(restore_valid), .restore_tag(restore_tag),
    .out_valid(out_valid), .out_tag(out_tag), .out_pdst(out_pdst),
    .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state built from the requirements
  int mmap[32];
  int fl[64];
  bit fl_rel[64];
  int hd, tl, seq, since;
  int ckm[4][32];
  int ckh[4];
  int pool[$];
  int gd[4], ga[4], gb[4];
  int last_pd[4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit rel, input bit rst_req, input int rtag);
    bit exp_stall;
    int epd[4], epa[4], epb[4];
    string ra[4], rb[4], rd[4];
    int etag;
    @(negedge clk);
    in_valid = 1'b1;
    for (int l = 0; l < 4; l++) begin
      in_dst[l*AW +: AW]   = AW'(gd[l]);
      in_src_a[l*AW +: AW] = AW'(ga[l]);
      in_src_b[l*AW +: AW] = AW'(gb[l]);
    end
    rel_valid     = rel;
    rel_preg      = rel ? PW'(pool[0]) : '0;
    restore_valid = rst_req;
    restore_tag   = TW'(rtag);
    #1;
    exp_stall = rst_req || ((tl - hd) < 4);
    chk(stall == exp_stall, rst_req ? "R10 stall during restore" : "R7 stall", stall, exp_stall);
    for (int l = 0; l < 4; l++) begin
      epd[l] = fl[(hd + l) % 64];
      rd[l]  = fl_rel[(hd + l) % 64] ? "R8 released reg reused" : "R3 pdst";
      epa[l] = mmap[ga[l]]; ra[l] = "R4 src_a";
      epb[l] = mmap[gb[l]]; rb[l] = "R4 src_b";
      for (int o = 0; o < l; o++) begin
        if (ga[l] == gd[o]) begin epa[l] = fl[(hd + o) % 64]; ra[l] = "R5 src_a"; end
        if (gb[l] == gd[o]) begin epb[l] = fl[(hd + o) % 64]; rb[l] = "R5 src_b"; end
      end
    end
    @(posedge clk);
    #1;
    etag = seq;
    if (rst_req) begin
      mmap = ckm[rtag];
      hd = ckh[rtag];
      seq = rtag;
      since = 0;
    end else if (!exp_stall) begin
      ckm[seq] = mmap;
      ckh[seq] = hd;
      for (int l = 0; l < 4; l++) begin
        mmap[gd[l]] = epd[l];
        pool.push_back(epd[l]);
      end
      hd += 4;
      seq = (seq + 1) % 4;
      since++;
    end
    if (rel) begin
      fl[tl % 64] = pool.pop_front();
      fl_rel[tl % 64] = 1'b1;
      tl++;
    end
    chk(out_valid == !exp_stall, "R2 out_valid", out_valid, !exp_stall);
    if (!exp_stall) begin
      chk(out_tag == TW'(etag), "R9 tag", out_tag, etag);
      for (int l = 0; l < 4; l++) begin
        last_pd[l] = out_pdst[l*PW +: PW];
        chk(out_pdst[l*PW +: PW] == PW'(epd[l]), rd[l], out_pdst[l*PW +: PW], epd[l]);
        chk(out_psrc_a[l*PW +: PW] == PW'(epa[l]), ra[l], out_psrc_a[l*PW +: PW], epa[l]);
        chk(out_psrc_b[l*PW +: PW] == PW'(epb[l]), rb[l], out_psrc_b[l*PW +: PW], epb[l]);
      end
    end
    in_valid = 1'b0;
    rel_valid = 1'b0;
    restore_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int g1;
    bit rel, rq;
    int rt;
    rst_n = 1'b0;
    in_valid = 1'b0; in_dst = '0; in_src_a = '0; in_src_b = '0;
    rel_valid = 1'b0; rel_preg = '0; restore_valid = 1'b0; restore_tag = '0;
    for (int i = 0; i < 32; i++) mmap[i] = i;
    for (int i = 0; i < 64; i++) begin fl[i] = (i < 32) ? 32 + i : 0; fl_rel[i] = 1'b0; end
    hd = 0; tl = 32; seq = 0; since = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(stall == 1'b0, "R1 stall after reset", stall, 0);

    // R1 identity map and initial allocation order
    for (int l = 0; l < 4; l++) begin gd[l] = 20 + l; ga[l] = l; gb[l] = 8 + l; end
    step(1'b0, 1'b0, 0);
    chk(out_psrc_b[3*PW +: PW] == 6'd11, "R1 identity map", out_psrc_b[3*PW +: PW], 11);
    chk(out_pdst[0 +: PW] == 6'd32, "R1 first free reg", out_pdst[0 +: PW], 32);

    // R6 every lane writes the same register
    for (int l = 0; l < 4; l++) begin gd[l] = 5; ga[l] = 1; gb[l] = 2; end
    step(1'b0, 1'b0, 0);
    g1 = last_pd[3];
    for (int l = 0; l < 4; l++) begin gd[l] = 24 + l; ga[l] = 5; gb[l] = 5; end
    step(1'b0, 1'b0, 0);
    chk(out_psrc_a[0 +: PW] == PW'(g1), "R6 youngest writer wins", out_psrc_a[0 +: PW], g1);

    // sweep over destination collision patterns with releases and rollbacks
    for (int k = 0; k < 300; k++) begin
      for (int l = 0; l < 4; l++) begin
        gd[l] = ((k & 255) >> (2 * l)) & 3;
        ga[l] = (k + 3 * l) & 3;
        gb[l] = ((k >> 2) + l) & 7;
      end
      rq = 1'b0; rt = 0;
      if ((k % 29) == 28 && since >= 2 && pool.size() >= 8) begin
        for (int j = 0; j < 8; j++) void'(pool.pop_back());
        rq = 1'b1;
        rt = (seq + 2) % 4;
      end
      rel = ((k % 2) == 0) && (pool.size() > 0);
      step(rel, rq, rt);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule